// File: doc/BRIEF.md
# Decimal Accumulator Processor

This block is a small stored-program processor whose words are four decimal digits, each held as a 4-bit BCD nibble. It owns a private memory of one thousand words, addressed by three decimal digits (000 to 999). The same memory holds both code and data: a stored word has no type attached to it. The core keeps six registers: a program counter, an instruction register, an accumulator, a memory address register, a memory buffer register, and a shadow copy of the program counter used by the interrupt.

The core performs exactly one register transfer on each clock. Fetching an instruction takes four steps. Executing a load, add or store takes three more, and a single interrupt-check step closes every instruction. If the interrupt request is high at that check and no handler is already running, the core saves the program counter in the shadow register and jumps to a fixed handler address. Returning from the handler puts the saved value back.

A debug port can write any memory word and read any memory word back. It is normally used to place a program in memory while reset is held, and to inspect the results once the core has halted.

Top module: `dac_core`

## Requirements
- R1: While reset is high, the program counter and accumulator read 0000, and both halted and in_isr read 0. Execution begins at address 000 once reset is released.
- R2: A fetch copies the program counter into the address register, reads memory into the buffer register, copies the buffer into the instruction register, and adds one to the program counter. A load or add therefore takes 8 clocks in total: fetch 4, execute 3, interrupt check 1. The halted output rises 12 clocks after reset is released for a program made of one load followed by a halting word.
- R3: An instruction word 1xyz (leading digit 1) loads the accumulator with the memory word at address xyz.
- R4: An instruction word 3xyz adds the memory word at address xyz to the accumulator. The addition is digit-wise BCD with carries between digits, and the result wraps modulo 10000.
- R5: An instruction word 2xyz writes the accumulator to the memory word at address xyz.
- R6: Memory does not tell instructions from data. A load from an address that holds an instruction returns that instruction's word.
- R7: At the interrupt check, when irq is high and in_isr is low, the core copies the program counter into the shadow register, sets the program counter to the parameter ISR_ADDR, and raises in_isr.
- R8: While in_isr is high, further interrupts are masked. The word 0999 restores the program counter from the shadow register and clears in_isr.
- R9: irq is sampled only at the interrupt check. A pulse that starts and ends between two checks has no effect.
- R10: A leading digit other than 1, 2 or 3, or a leading digit 0 whose operand is not 999, puts the core into a halt state. In that state halted stays high and the program counter and accumulator stay frozen until reset.
- R11: When dbg_we is high, dbg_wdata is written at dbg_addr. dbg_rdata always shows the memory word at dbg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request, sampled at the interrupt check |
| halted | output | 1 | High while the core is in the halt state |
| in_isr | output | 1 | High while the interrupt handler runs |
| pc_q | output | 16 | Program counter (4 BCD digits) |
| acc_q | output | 16 | Accumulator (4 BCD digits) |
| dbg_we | input | 1 | Debug memory write enable |
| dbg_addr | input | 12 | Debug memory address (3 BCD digits) |
| dbg_wdata | input | 16 | Debug write data (4 BCD digits) |
| dbg_rdata | output | 16 | Memory word at dbg_addr |

## Verification
The bench builds the core with ISR_ADDR set to 050 instead of the default 900. This puts the handler a short, readable distance from the main program, so the return address and the handler's effect on the accumulator can be predicted by hand. A handler two additions long is run while irq stays high throughout it. This shows the mask at work: each handler instruction is counted exactly once before the return restores the saved program counter.

// File: rtl/dac_pkg.sv
package dac_pkg;

    localparam int DIGIT_W     = 4;
    localparam int WORD_DIGITS = 4;
    localparam int ADDR_DIGITS = 3;
    localparam int WORD_W      = DIGIT_W * WORD_DIGITS;
    localparam int ADDR_W      = DIGIT_W * ADDR_DIGITS;
    localparam int MEM_DEPTH   = 10 ** ADDR_DIGITS;
    localparam int IDX_W       = $clog2(MEM_DEPTH);

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [IDX_W-1:0]   idx_t;

    localparam digit_t OP_SYS   = 4'h0;
    localparam digit_t OP_LOAD  = 4'h1;
    localparam digit_t OP_STORE = 4'h2;
    localparam digit_t OP_ADD   = 4'h3;
    localparam addr_t  RET_OPND = 12'h999;

    typedef enum logic [3:0] {
        ST_F_MAR, ST_F_MBR, ST_F_IR, ST_F_PC,
        ST_X_MAR, ST_X_MBR, ST_X_ACC,
        ST_S_MAR, ST_S_MBR, ST_S_MEM,
        ST_RET, ST_CHK, ST_HALT
    } state_t;

    typedef struct packed {
        word_t pc;
        word_t ir;
        word_t acc;
        addr_t mar;
        word_t mbr;
        word_t shadow;
        logic  in_isr;
    } regs_t;

    function automatic digit_t opcode_of(word_t w);
        return w[WORD_W-1 -: DIGIT_W];
    endfunction

    function automatic addr_t operand_of(word_t w);
        return w[ADDR_W-1:0];
    endfunction

    // Binary index of a BCD address; values above MEM_DEPTH-1 flag bad digits.
    function automatic int unsigned bcd_index(addr_t a);
        int unsigned idx;
        idx = 0;
        for (int d = ADDR_DIGITS - 1; d >= 0; d--) begin
            idx = idx * 10 + 32'(a[d*DIGIT_W +: DIGIT_W]);
        end
        return idx;
    endfunction

endpackage

// File: rtl/dac_bcd_adder.sv
module dac_bcd_adder
    import dac_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic [DIGITS*DIGIT_W-1:0] a,
    input  logic [DIGITS*DIGIT_W-1:0] b,
    input  logic                      cin,
    output logic [DIGITS*DIGIT_W-1:0] sum
);
    logic [DIGITS-1:0] carry;
    assign carry[0] = cin;

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [DIGIT_W:0] raw;
        logic             over;
        always_comb begin
            raw  = {1'b0, a[i*DIGIT_W +: DIGIT_W]} + {1'b0, b[i*DIGIT_W +: DIGIT_W]}
                 + {{DIGIT_W{1'b0}}, carry[i]};
            over = (raw > 5'd9);
            sum[i*DIGIT_W +: DIGIT_W] = over ? (raw[DIGIT_W-1:0] + 4'd6) : raw[DIGIT_W-1:0];
        end
        if (i < DIGITS - 1) begin : g_carry
            assign carry[i+1] = over;
        end
    end
endmodule

// File: rtl/dac_mem.sv
module dac_mem
    import dac_pkg::*;
(
    input  logic  clk,
    input  logic  core_we,
    input  addr_t core_addr,
    input  word_t core_wdata,
    output word_t core_rdata,
    input  logic  dbg_we,
    input  addr_t dbg_addr,
    input  word_t dbg_wdata,
    output word_t dbg_rdata
);
    word_t       cells [MEM_DEPTH];
    int unsigned core_i, dbg_i;
    logic        core_ok, dbg_ok;
    idx_t        core_ix, dbg_ix;

    always_comb begin
        core_i  = bcd_index(core_addr);
        dbg_i   = bcd_index(dbg_addr);
        core_ok = (core_i < MEM_DEPTH);
        dbg_ok  = (dbg_i < MEM_DEPTH);
        core_ix = IDX_W'(core_i);
        dbg_ix  = IDX_W'(dbg_i);
    end

    always_ff @(posedge clk) begin
        if (dbg_we && dbg_ok) begin
            cells[dbg_ix] <= dbg_wdata;
        end else if (core_we && core_ok) begin
            cells[core_ix] <= core_wdata;
        end
    end

    assign core_rdata = core_ok ? cells[core_ix] : '0;
    assign dbg_rdata  = dbg_ok  ? cells[dbg_ix]  : '0;
endmodule

// File: rtl/dac_core.sv
module dac_core
    import dac_pkg::*;
#(
    parameter logic [11:0] ISR_ADDR = 12'h900
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq,
    output logic        halted,
    output logic        in_isr,
    output logic [15:0] pc_q,
    output logic [15:0] acc_q,
    input  logic        dbg_we,
    input  logic [11:0] dbg_addr,
    input  logic [15:0] dbg_wdata,
    output logic [15:0] dbg_rdata
);
    localparam int PAD_W = WORD_W - ADDR_W;

    state_t st, st_nxt;
    regs_t  r, rn;
    word_t  mem_rdata, acc_sum, pc_inc;

    dac_bcd_adder #(.DIGITS(WORD_DIGITS)) u_acc_add (
        .a(r.acc), .b(r.mbr), .cin(1'b0), .sum(acc_sum)
    );

    dac_bcd_adder #(.DIGITS(WORD_DIGITS)) u_pc_inc (
        .a(r.pc), .b('0), .cin(1'b1), .sum(pc_inc)
    );

    dac_mem u_mem (
        .clk(clk),
        .core_we(st == ST_S_MEM), .core_addr(r.mar), .core_wdata(r.mbr),
        .core_rdata(mem_rdata),
        .dbg_we(dbg_we), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata)
    );

    always_comb begin
        rn     = r;
        st_nxt = st;
        unique case (st)
            ST_F_MAR: begin rn.mar = r.pc[ADDR_W-1:0]; st_nxt = ST_F_MBR; end
            ST_F_MBR: begin rn.mbr = mem_rdata;        st_nxt = ST_F_IR;  end
            ST_F_IR:  begin rn.ir  = r.mbr;            st_nxt = ST_F_PC;  end
            ST_F_PC: begin
                rn.pc = pc_inc;
                case (opcode_of(r.ir))
                    OP_LOAD, OP_ADD: st_nxt = ST_X_MAR;
                    OP_STORE:        st_nxt = ST_S_MAR;
                    OP_SYS:          st_nxt = (operand_of(r.ir) == RET_OPND) ? ST_RET : ST_HALT;
                    default:         st_nxt = ST_HALT;
                endcase
            end
            ST_X_MAR: begin rn.mar = operand_of(r.ir); st_nxt = ST_X_MBR; end
            ST_X_MBR: begin rn.mbr = mem_rdata;        st_nxt = ST_X_ACC; end
            ST_X_ACC: begin
                rn.acc = (opcode_of(r.ir) == OP_ADD) ? acc_sum : r.mbr;
                st_nxt = ST_CHK;
            end
            ST_S_MAR: begin rn.mar = operand_of(r.ir); st_nxt = ST_S_MBR; end
            ST_S_MBR: begin rn.mbr = r.acc;            st_nxt = ST_S_MEM; end
            ST_S_MEM: st_nxt = ST_CHK;
            ST_RET: begin
                rn.pc     = r.shadow;
                rn.in_isr = 1'b0;
                st_nxt    = ST_CHK;
            end
            ST_CHK: begin
                if (irq && !r.in_isr) begin
                    rn.shadow = r.pc;
                    rn.pc     = {{PAD_W{1'b0}}, ISR_ADDR};
                    rn.in_isr = 1'b1;
                end
                st_nxt = ST_F_MAR;
            end
            ST_HALT: st_nxt = ST_HALT;
            default: st_nxt = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r  <= '0;
            st <= ST_F_MAR;
        end else begin
            r  <= rn;
            st <= st_nxt;
        end
    end

    assign halted = (st == ST_HALT);
    assign in_isr = r.in_isr;
    assign pc_q   = r.pc;
    assign acc_q  = r.acc;
endmodule

// File: rtl/dac_core_chk.sv
module dac_core_chk #(
    parameter logic [11:0] ISR_ADDR = 12'h900
) (
    input logic        clk,
    input logic        rst,
    input logic        irq,
    input logic        halted,
    input logic        in_isr,
    input logic [15:0] pc_q,
    input logic [15:0] acc_q
);
    logic rst_d;
    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d && rst) begin
            AST_RESET_CLEAR: assert (pc_q == 16'h0 && acc_q == 16'h0 && !halted && !in_isr); // R1
        end
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(pc_q) && $stable(acc_q)); // R10

    AST_ISR_TARGET: assert property (@(posedge clk) disable iff (rst)
        $rose(in_isr) |-> pc_q == {4'h0, ISR_ADDR}); // R7

    AST_ISR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(in_isr) |-> $past(irq)); // R9

    AST_RETURN_LEAVES: assert property (@(posedge clk) disable iff (rst)
        $fell(in_isr) |-> pc_q != {4'h0, ISR_ADDR}); // R8
endmodule

bind dac_core dac_core_chk #(.ISR_ADDR(ISR_ADDR)) u_chk (
    .clk(clk), .rst(rst), .irq(irq), .halted(halted),
    .in_isr(in_isr), .pc_q(pc_q), .acc_q(acc_q)
);

// File: tb/dac_core_tb.sv
module dac_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0;
    logic        halted, in_isr;
    logic [15:0] pc_q, acc_q, dbg_wdata, dbg_rdata;
    logic        dbg_we = 1'b0;
    logic [11:0] dbg_addr = '0;

    int checks = 0;
    int errors = 0;
    int cyc, halt_cyc, irq_on, irq_off;
    logic [15:0] irq_drop_pc;
    logic saw_isr;

    always #4 clk = ~clk;

    dac_core #(.ISR_ADDR(12'h050)) u_dut (
        .clk(clk), .rst(rst), .irq(irq), .halted(halted), .in_isr(in_isr),
        .pc_q(pc_q), .acc_q(acc_q), .dbg_we(dbg_we), .dbg_addr(dbg_addr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        dbg_addr = a; dbg_wdata = d; dbg_we = 1'b1;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [15:0] d);
        dbg_addr = a;
        #1 d = dbg_rdata;
    endtask

    task automatic hold_reset();
        rst = 1'b1; irq = 1'b0; irq_on = -1; irq_off = -1; irq_drop_pc = 16'hFFFF;
        @(negedge clk);
    endtask

    task automatic run(input int max_cyc);
        rst = 1'b0; cyc = 0; saw_isr = 1'b0;
        while (!halted && cyc < max_cyc) begin
            @(negedge clk);
            cyc++;
            if (cyc == irq_on) irq = 1'b1;
            if (cyc == irq_off || pc_q == irq_drop_pc) irq = 1'b0;
            if (in_isr) saw_isr = 1'b1;
        end
        halt_cyc = cyc;
        if (!halted) begin
            checks++; errors++;
            $display("FAIL run: core did not halt, actual running expected halted");
        end
    endtask

    task automatic t_reset();
        logic [15:0] d;
        hold_reset();
        repeat (2) @(negedge clk);
        check("R1 pc", pc_q, 16'h0000);
        check("R1 acc", acc_q, 16'h0000);
        check("R1 halted", {15'd0, halted}, 16'h0);
        check("R1 in_isr", {15'd0, in_isr}, 16'h0);
        poke(12'h777, 16'h4321);
        peek(12'h777, d);
        check("R11 debug readback", d, 16'h4321);
    endtask

    task automatic t_sum(input logic [15:0] x, input logic [15:0] y, input logic [15:0] s);
        logic [15:0] d;
        hold_reset();
        poke(12'h000, 16'h1010); poke(12'h001, 16'h3011);
        poke(12'h002, 16'h2012); poke(12'h003, 16'h9000);
        poke(12'h010, x); poke(12'h011, y); poke(12'h012, 16'h0000);
        run(200);
        check("R4 bcd sum", acc_q, s);
        peek(12'h012, d);
        check("R5 stored word", d, s);
        check("R2 pc after four fetches", pc_q, 16'h0004);
    endtask

    task automatic t_timing();
        hold_reset();
        poke(12'h000, 16'h1010); poke(12'h001, 16'h9000); poke(12'h010, 16'h0005);
        run(200);
        check("R2 clocks to halt", 16'(halt_cyc), 16'd12);
        check("R3 load", acc_q, 16'h0005);
    endtask

    task automatic t_self();
        hold_reset();
        poke(12'h000, 16'h1000); poke(12'h001, 16'h9000);
        run(200);
        check("R6 instruction read as data", acc_q, 16'h1000);
    endtask

    task automatic t_pulse();
        hold_reset();
        poke(12'h000, 16'h1010); poke(12'h001, 16'h9000); poke(12'h010, 16'h0001);
        irq_on = 1; irq_off = 3;
        run(200);
        check("R9 pulse ignored", {15'd0, saw_isr}, 16'h0);
        check("R9 pc", pc_q, 16'h0002);
        check("R9 acc", acc_q, 16'h0001);
    endtask

    task automatic t_irq();
        hold_reset();
        poke(12'h000, 16'h1010); poke(12'h001, 16'h3011); poke(12'h002, 16'h9000);
        poke(12'h010, 16'h0001); poke(12'h011, 16'h0002); poke(12'h012, 16'h0100);
        poke(12'h050, 16'h3012); poke(12'h051, 16'h3012); poke(12'h052, 16'h0999);
        irq_on = 2; irq_off = 100000; irq_drop_pc = 16'h0053;
        run(400);
        check("R7 handler entered", {15'd0, saw_isr}, 16'h1);
        check("R8 handler ran once", acc_q, 16'h0203);
        check("R8 return address", pc_q, 16'h0003);
        check("R8 unmasked after return", {15'd0, in_isr}, 16'h0);
    endtask

    task automatic t_halt();
        logic [15:0] p;
        hold_reset();
        poke(12'h000, 16'h0123);
        run(200);
        check("R10 halted", {15'd0, halted}, 16'h1);
        check("R10 pc", pc_q, 16'h0001);
        p = pc_q;
        repeat (10) @(negedge clk);
        check("R10 pc frozen", pc_q, p);
        check("R10 still halted", {15'd0, halted}, 16'h1);
        hold_reset();
        poke(12'h000, 16'h1010); poke(12'h001, 16'h7000); poke(12'h010, 16'h0042);
        run(200);
        check("R10 opcode 7 halts", pc_q, 16'h0002);
        check("R10 acc kept", acc_q, 16'h0042);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_sum(16'h0001, 16'h0009, 16'h0010);
        t_sum(16'h9999, 16'h0001, 16'h0000);
        t_sum(16'h0456, 16'h0567, 16'h1023);
        t_timing();
        t_self();
        t_pulse();
        t_irq();
        t_halt();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule